// File: doc/BRIEF.md
# Latched GPIO Input Port with Change Interrupt

This block watches a 16-bit group of input pins, organised as two 8-bit ports. It raises an active-low interrupt whenever a pin no longer matches the value the host last saw for it. Each pin can be set to one of two modes. In non-latched mode a read returns the live level, and a change that reverts before any read withdraws its own interrupt. In latched mode the first change after a read is captured and held. The following read reports that held value even if the pin has already gone back.

The host reaches the block through a plain synchronous register interface with an address, a write enable with write data, and a read strobe. Read data appears one cycle after the strobe. The interface has no back-pressure. Every access completes in the cycle it is issued, so the interface needs no valid/ready handshake. Reading a port's input register takes a snapshot of that port: it becomes the new reference for change detection and releases any held captures in that port.

Top module: `lgpio_latched_in`

## Requirements
- R1: After reset, both latch-enable registers read 00h. `irq_n` stays 1 once the input synchronizers have filled, whatever level the pins held through reset.
- R2: The address map is as follows. 00h returns pins 7:0 and 01h returns pins 15:8, with bit n of the byte belonging to the nth pin of that port. 44h and 45h are the latch-enable registers for the lower and upper port, where a bit value of 1 means latched. Any other address reads 00h. `rd_data` changes only on the clock edge that samples `rd_en`.
- R3: A write to 00h or 01h changes no register: both latch-enable registers and the input readback keep their values.
- R4: For a non-latched pin, `irq_n` goes to 0 while the pin differs from its last-read value. It returns to 1 with no read if the pin goes back.
- R5: For a latched pin, the first change after a read is held. The next read of its port returns the held level, and the read after that returns the live level.
- R6: A read of one port clears only that port's pending sources. `irq_n` returns to 1 two edges after the read unless another source is still pending.
- R7: A latched pin and a non-latched pin may change on the same cycle, with the non-latched pin then reverting. `irq_n` stays 0 until the port is read. That read shows only the latched pin's change and clears the interrupt.
- R8: Switching a pin with a held capture from latched to non-latched keeps the interrupt pending until its port is read. From then on, reads of that pin return its live level.
- R9: Switching a pin from non-latched to latched makes reads return its latched level. A difference that was already pending at the switch is captured.
- R10: A pin change first drives `irq_n` low on the third rising edge after it is applied: two synchronizer stages followed by the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | 16 | Raw pin levels, asynchronous to clk |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; also snapshots an input port |
| rd_data | output | 8 | Read data, registered |
| irq_n | output | 1 | Change interrupt, active low |

## Verification
Two functions can land on the same edge: capture of a latched change, and the change detection on a non-latched neighbour in the same port, when both pins move together. The bench provokes this by driving a latched and a non-latched bit in one write of the pins and then reverting only the non-latched one. It judges the outcome through `irq_n`, which must stay low, and through the single read, which must report only the latched change. Port isolation is exercised the same way: sources pending in both ports at once are cleared one port at a time, with `irq_n` observed between the two reads.

// File: rtl/lgpio_pkg.sv
package lgpio_pkg;
  // Kind of register selected by an address
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_INPUT = 2'd1,
    SEL_CFG   = 2'd2
  } sel_kind_e;
endpackage

// File: rtl/lgpio_sync.sv
module lgpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lgpio_decode.sv
module lgpio_decode
  import lgpio_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned PORTS    = 2,
  parameter int unsigned IN_BASE  = 'h00,
  parameter int unsigned CFG_BASE = 'h44,
  localparam int unsigned IDX_W   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    kind = SEL_NONE;
    idx  = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (addr == ADDR_W'(IN_BASE + p)) begin
        kind = SEL_INPUT;
        idx  = IDX_W'(p);
      end
      if (addr == ADDR_W'(CFG_BASE + p)) begin
        kind = SEL_CFG;
        idx  = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/lgpio_port.sv
module lgpio_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_busy,
  input  logic [W-1:0] live,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_wdata,
  input  logic         rd_clr,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] rd_value,
  output logic [W-1:0] held_q,
  output logic         pending_any
);
  logic [W-1:0] latch_en_q;  // 1 = latched mode
  logic [W-1:0] snap_q;      // level seen by the host at the last read
  logic [W-1:0] held_val_q;  // captured level of a latched change
  logic [W-1:0] diff;
  logic [W-1:0] capture;
  logic [W-1:0] show_held;

  assign diff      = live ^ snap_q;
  assign capture   = latch_en_q & ~held_q & diff;
  assign show_held = latch_en_q & held_q;
  assign rd_value  = (show_held & held_val_q) | (~show_held & live);
  assign cfg_q     = latch_en_q;
  // A held capture stays a source even after its pin leaves latched mode
  assign pending_any = |(held_q | diff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_en_q <= '0;
    end else if (cfg_we) begin
      latch_en_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q     <= '0;
      held_q     <= '0;
      held_val_q <= '0;
    end else if (init_busy || rd_clr) begin
      // Snapshot takes the live level; a read's returned value is already out
      snap_q <= live;
      held_q <= '0;
    end else begin
      held_q     <= held_q | capture;
      held_val_q <= (capture & live) | (~capture & held_val_q);
    end
  end
endmodule

// File: rtl/lgpio_latched_in.sv
module lgpio_latched_in
  import lgpio_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned PORTS       = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned IN_BASE     = 'h00,
  parameter int unsigned CFG_BASE    = 'h44,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PIN_W      = PORT_W * PORTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  pins,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [PORT_W-1:0] rd_data,
  output logic              irq_n
);
  localparam int unsigned IDX_W    = (PORTS > 1) ? $clog2(PORTS) : 1;
  localparam int unsigned INIT_CYC = SYNC_STAGES + 1;
  localparam int unsigned CNT_W    = $clog2(INIT_CYC + 1);

  logic [PIN_W-1:0]  live;
  sel_kind_e         sel_kind;
  logic [IDX_W-1:0]  sel_idx;
  logic [CNT_W-1:0]  init_cnt_q;
  logic              init_busy;
  logic [PORT_W-1:0] rd_vals  [PORTS];
  logic [PORT_W-1:0] cfg_vals [PORTS];
  logic [PORTS-1:0]  port_pend;
  logic [PIN_W-1:0]  held_all;
  logic [PIN_W-1:0]  cfg_all;

  lgpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins),
    .q     (live)
  );

  lgpio_decode #(
    .ADDR_W   (ADDR_W),
    .PORTS    (PORTS),
    .IN_BASE  (IN_BASE),
    .CFG_BASE (CFG_BASE)
  ) dec_i (
    .addr (addr),
    .kind (sel_kind),
    .idx  (sel_idx)
  );

  // Snapshots track the pins until the synchronizer holds real levels
  assign init_busy = (init_cnt_q != CNT_W'(INIT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         init_cnt_q <= '0;
    else if (init_busy) init_cnt_q <= init_cnt_q + 1'b1;
  end

  for (genvar g = 0; g < PORTS; g++) begin : g_port
    logic hit;
    assign hit = (sel_idx == IDX_W'(g));

    lgpio_port #(.W(PORT_W)) port_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_busy   (init_busy),
      .live        (live[g*PORT_W +: PORT_W]),
      .cfg_we      (wr_en && (sel_kind == SEL_CFG) && hit),
      .cfg_wdata   (wr_data),
      .rd_clr      (rd_en && (sel_kind == SEL_INPUT) && hit),
      .cfg_q       (cfg_vals[g]),
      .rd_value    (rd_vals[g]),
      .held_q      (held_all[g*PORT_W +: PORT_W]),
      .pending_any (port_pend[g])
    );

    assign cfg_all[g*PORT_W +: PORT_W] = cfg_vals[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (sel_kind)
        SEL_INPUT: rd_data <= rd_vals[sel_idx];
        SEL_CFG:   rd_data <= cfg_vals[sel_idx];
        default:   rd_data <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_n <= 1'b1;
    else if (init_busy) irq_n <= 1'b1;
    else                irq_n <= ~(|port_pend);
  end
endmodule

// File: rtl/lgpio_latched_in_chk.sv
module lgpio_latched_in_chk #(
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned PORTS    = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned IN_BASE  = 'h00,
  parameter int unsigned CFG_BASE = 'h44,
  localparam int unsigned PIN_W   = PORT_W * PORTS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [PORT_W-1:0] rd_data,
  input logic              irq_n,
  input logic              init_busy,
  input logic [PIN_W-1:0]  cfg_all,
  input logic [PIN_W-1:0]  held_all
);
  logic cfg_hit;

  always_comb begin
    cfg_hit = 1'b0;
    for (int p = 0; p < PORTS; p++)
      if (addr == ADDR_W'(CFG_BASE + p)) cfg_hit = 1'b1;
  end

  p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |=> irq_n);

  p_rd_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_cfg_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cfg_hit) |=> $stable(cfg_all));

  for (genvar g = 0; g < PORTS; g++) begin : g_chk
    logic rd_this;
    logic wr_cfg_this;
    assign rd_this     = rd_en && (addr == ADDR_W'(IN_BASE + g));
    assign wr_cfg_this = wr_en && (addr == ADDR_W'(CFG_BASE + g));

    p_held_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_this |=> ((held_all[g*PORT_W +: PORT_W] & $past(held_all[g*PORT_W +: PORT_W]))
                    == $past(held_all[g*PORT_W +: PORT_W])));

    p_read_clears_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_this |=> (held_all[g*PORT_W +: PORT_W] == '0));

    p_mode_switch_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cfg_this && !rd_this) |=>
        ((held_all[g*PORT_W +: PORT_W] & $past(held_all[g*PORT_W +: PORT_W]))
         == $past(held_all[g*PORT_W +: PORT_W])));
  end
endmodule

bind lgpio_latched_in lgpio_latched_in_chk #(
  .PORT_W   (PORT_W),
  .PORTS    (PORTS),
  .ADDR_W   (ADDR_W),
  .IN_BASE  (IN_BASE),
  .CFG_BASE (CFG_BASE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .irq_n     (irq_n),
  .init_busy (init_busy),
  .cfg_all   (cfg_all),
  .held_all  (held_all)
);

// File: tb/lgpio_latched_in_tb_top.sv
module lgpio_latched_in_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pins = 16'h0F0F;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lgpio_latched_in dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins    (pins),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .irq_n   (irq_n)
  );

  // {pins, expected irq_n after settling}; non-latched mode throughout
  localparam logic [16:0] VEC [7] = '{
    {16'h0F0E, 1'b1},
    {16'h00A5, 1'b0},
    {16'hA500, 1'b0},
    {16'hFFFF, 1'b0},
    {16'h1234, 1'b0},
    {16'h1234, 1'b1},
    {16'h0000, 1'b0}
  };

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] v);
    addr  = a;
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    addr    = a;
    wr_data = d;
    wr_en   = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    @(negedge clk);
    step(4);
    rst_n = 1'b1;
    step(8);

    // R1: reset state with pins high in both ports
    chk("R1 irq_n after reset", {15'd0, irq_n}, 16'd1);
    reg_rd(8'h44, v); chk("R1 latch cfg port0", {8'd0, v}, 16'h00);
    reg_rd(8'h45, v); chk("R1 latch cfg port1", {8'd0, v}, 16'h00);

    // R2: address map
    reg_rd(8'h00, v); chk("R2 port0 input", {8'd0, v}, 16'h0F);
    reg_rd(8'h01, v); chk("R2 port1 input", {8'd0, v}, 16'h0F);
    reg_rd(8'h10, v); chk("R2 unmapped address", {8'd0, v}, 16'h00);
    reg_wr(8'h45, 8'h3C);
    reg_rd(8'h45, v); chk("R2 cfg port1 readback", {8'd0, v}, 16'h3C);
    reg_wr(8'h45, 8'h00);
    step(2);
    chk("R2 rd_data held without strobe", {8'd0, rd_data}, 16'h3C);

    // R3: writes to input registers are ignored
    reg_wr(8'h00, 8'hFF);
    reg_wr(8'h01, 8'hAA);
    reg_rd(8'h44, v); chk("R3 cfg0 after input write", {8'd0, v}, 16'h00);
    reg_rd(8'h45, v); chk("R3 cfg1 after input write", {8'd0, v}, 16'h00);
    reg_rd(8'h00, v); chk("R3 port0 still live", {8'd0, v}, 16'h0F);
    step(2);
    chk("R3 no interrupt from write", {15'd0, irq_n}, 16'd1);

    // R10: latency from pin to irq_n
    pins = 16'h0F0E;
    step(2);
    chk("R10 irq_n still high after two edges", {15'd0, irq_n}, 16'd1);
    step(1);
    chk("R10 irq_n low on third edge", {15'd0, irq_n}, 16'd0);
    reg_rd(8'h00, v); chk("R10 port0 value", {8'd0, v}, 16'h0E);
    step(2);
    chk("R6 irq_n released after read", {15'd0, irq_n}, 16'd1);

    // R4/R6: table of non-latched patterns
    for (int k = 0; k < 7; k++) begin
      pins = VEC[k][16:1];
      step(5);
      chk($sformatf("R4 vec%0d irq_n", k), {15'd0, irq_n}, {15'd0, VEC[k][0]});
      reg_rd(8'h00, v); chk($sformatf("R2 vec%0d port0", k), {8'd0, v}, {8'd0, VEC[k][8:1]});
      reg_rd(8'h01, v); chk($sformatf("R2 vec%0d port1", k), {8'd0, v}, {8'd0, VEC[k][16:9]});
      step(2);
      chk($sformatf("R6 vec%0d irq_n after reads", k), {15'd0, irq_n}, 16'd1);
    end

    // R4: transient on a non-latched pin withdraws itself
    pins = 16'h0008;
    step(5);
    chk("R4 transient asserts", {15'd0, irq_n}, 16'd0);
    pins = 16'h0000;
    step(5);
    chk("R4 transient withdrawn without read", {15'd0, irq_n}, 16'd1);

    // R5: latched pulse held until read
    reg_wr(8'h44, 8'h01);
    pins = 16'h0001; step(4);
    pins = 16'h0000; step(5);
    chk("R5 held change keeps irq", {15'd0, irq_n}, 16'd0);
    reg_rd(8'h00, v); chk("R5 first read returns held", {8'd0, v}, 16'h01);
    step(2);
    chk("R5 irq released", {15'd0, irq_n}, 16'd1);
    reg_rd(8'h00, v); chk("R5 second read returns live", {8'd0, v}, 16'h00);

    // R6: ports cleared independently
    pins = 16'h0101; step(5);
    pins = 16'h0100; step(5);
    reg_rd(8'h01, v); chk("R6 port1 read", {8'd0, v}, 16'h01);
    step(2);
    chk("R6 port0 still pending", {15'd0, irq_n}, 16'd0);
    reg_rd(8'h00, v); chk("R6 port0 read", {8'd0, v}, 16'h01);
    step(2);
    chk("R6 all clear", {15'd0, irq_n}, 16'd1);
    pins = 16'h0000; step(5);
    chk("R6 port1 change pending", {15'd0, irq_n}, 16'd0);
    reg_rd(8'h01, v); chk("R6 port1 back to zero", {8'd0, v}, 16'h00);
    step(2);
    chk("R6 port1 cleared", {15'd0, irq_n}, 16'd1);

    // R7: latched bit0 and non-latched bit1 switch together
    pins = 16'h0003; step(5);
    pins = 16'h0001; step(5);
    chk("R7 irq stays asserted", {15'd0, irq_n}, 16'd0);
    reg_rd(8'h00, v); chk("R7 read shows latched change only", {8'd0, v}, 16'h01);
    step(2);
    chk("R7 read clears irq", {15'd0, irq_n}, 16'd1);
    pins = 16'h0000; step(5);
    chk("R7 latched fall pending", {15'd0, irq_n}, 16'd0);
    reg_rd(8'h00, v); chk("R7 latched fall read", {8'd0, v}, 16'h00);
    step(2);
    chk("R7 fall cleared", {15'd0, irq_n}, 16'd1);

    // R8: latched -> non-latched keeps pending, reads go live
    pins = 16'h0001; step(4);
    pins = 16'h0000; step(5);
    reg_wr(8'h44, 8'h00);
    step(3);
    chk("R8 pending survives mode switch", {15'd0, irq_n}, 16'd0);
    reg_rd(8'h00, v); chk("R8 read returns live level", {8'd0, v}, 16'h00);
    step(2);
    chk("R8 read clears irq", {15'd0, irq_n}, 16'd1);

    // R9: non-latched -> latched captures pending difference
    pins = 16'h0004; step(5);
    chk("R9 non-latched change pending", {15'd0, irq_n}, 16'd0);
    reg_wr(8'h44, 8'h04);
    step(3);
    pins = 16'h0000; step(5);
    chk("R9 irq still asserted", {15'd0, irq_n}, 16'd0);
    reg_rd(8'h00, v); chk("R9 read returns latched level", {8'd0, v}, 16'h04);
    step(2);
    chk("R9 irq cleared", {15'd0, irq_n}, 16'd1);
    reg_rd(8'h00, v); chk("R9 next read live", {8'd0, v}, 16'h00);

    done = 1'b1;
    finish_run();
  end
endmodule